// File: doc/BRIEF.md
# Divider Output Synchronization Controller

This block drives a set of programmable clock-divider channels that all run from one divider-input clock. When any synchronization source is active, every channel that is not excluded is frozen at its own programmed static level, and its counter is loaded with its phase offset. After all sources have gone away, a fixed latency counter runs. When it expires, every such channel starts counting on the same input edge. The edges of different channels can therefore be aligned, or spaced apart on purpose through their phase offsets.

Six sources can hold the channels:
- an active-low asynchronous sync pin, which passes through a two-flop synchronizer;
- three staged control bits (soft sync, soft reset and distribution power-down), which act only when an update strobe copies the staged value into the active copy;
- a power-down input;
- a calibration-busy flag.

Chip reset also starts the same release sequence. A channel with its exclude bit set ignores all of these sources and keeps dividing.

Top module: `divsync_top`

## Requirements
- R1: While reset is low, every channel output equals its start level. After reset is released, the first edge on which reset is sampled high is edge 0. Non-excluded outputs stay at the start level through edge LAT, and the first divider step takes place on edge LAT+1.
- R2: While the sync pin is held low, every non-excluded output is held at its start level. This takes effect within three clock edges of the pin falling.
- R3: Edge 0 is the first clock edge that samples the sync pin high after a low period. Non-excluded outputs stay static through edge LAT+2, and the first divider step takes place on edge LAT+3. With the default LAT of 11, clocking resumes on the 15th edge.
- R4: A channel has ratio R = div_m1 + 1, which ranges from 1 to 32. For R of 2 or more, the channel counts c = 0..R-1 cyclically. Its output equals the start level when c < R - floor(R/2) and the inverted start level otherwise, so even ratios give a 50% duty cycle. For R = 1, the output inverts on every edge, and the first step drives the inverted start level.
- R5: On release, a channel's counter starts from (phase mod R). Its first divider step moves the count to (phase mod R + 1) mod R.
- R6: A channel whose exclude bit is 1 keeps dividing while a sync is held.
- R7: Setting or clearing the staged soft-sync bit has no effect until an update strobe is sampled high. When the strobe is sampled on edge 0 with the bit cleared, the first divider step takes place on edge LAT+2.
- R8: The staged soft-reset bit and the staged distribution power-down bit behave as in R7. The power-down input and the calibration-busy flag hold the channels while they are high. When either is sampled low on edge 0, the first divider step takes place on edge LAT+1.
- R9: If any sync source becomes active again during the release countdown, the countdown starts over. The channels stay static until a full latency has elapsed after the final release.
- R10: All non-excluded channels take their first divider step on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider-input clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert |
| sync_n | input | 1 | Asynchronous sync pin, active low |
| pwrdn | input | 1 | Power-down request, active high |
| cal_busy | input | 1 | Calibration in progress, active high |
| soft_sync_stage | input | 1 | Staged soft-sync control bit |
| soft_rst_stage | input | 1 | Staged soft-reset control bit |
| dist_pd_stage | input | 1 | Staged distribution power-down bit |
| upd_strobe | input | 1 | Copies the staged bits into the active copies |
| ch_excl | input | NCH | Per-channel exclude from synchronization |
| ch_div_m1 | input | NCH*DW | Per-channel divide ratio minus one |
| ch_phase | input | NCH*DW | Per-channel phase offset in input cycles |
| ch_start | input | NCH | Per-channel static start level |
| ch_out | output | NCH | Divided channel outputs |
| hold_o | output | 1 | High whenever the non-excluded dividers are stopped |

## Verification
An error in the latency counter or in the merge of the sources shows up as the first output step landing on the wrong edge. The bench samples every edge around the release, so an offset of a single cycle is visible. A wrong preload or wrong divider state shows up as a wrong output level within one period of the channel, which is at most 32 cycles after release. A source that leaks through without a strobe, or an excluded channel that gets frozen, shows up as a static output where the bench expects an output that is still dividing, within two edges of the stimulus.

// File: rtl/divsync_pkg.sv
package divsync_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_CNT  = 2'd1,
        ST_RUN  = 2'd2
    } sync_st_e;

endpackage

// File: rtl/divsync_pinsync.sv
module divsync_pinsync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_s
);
    typedef struct packed {
        logic meta;
        logic stab;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = pin_n;
        r_d.stab = r_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{meta: 1'b1, stab: 1'b1};
        else        r_q <= r_d;
    end

    assign pin_s = r_q.stab;
endmodule

// File: rtl/divsync_ctrl.sv
module divsync_ctrl
    import divsync_pkg::*;
#(
    parameter int LAT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic pwrdn,
    input  logic cal_busy,
    input  logic ss_stage,
    input  logic sr_stage,
    input  logic dp_stage,
    input  logic upd,
    output logic en_o
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        sync_st_e        st;
        logic [CW-1:0]   cnt;
        logic            ss;
        logic            sr;
        logic            dp;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  hold_raw;

    always_comb begin
        hold_raw = ~pin_s | r_q.ss | r_q.sr | r_q.dp | pwrdn | cal_busy;
        r_d = r_q;
        if (upd) begin
            r_d.ss = ss_stage;
            r_d.sr = sr_stage;
            r_d.dp = dp_stage;
        end
        if (hold_raw) begin
            r_d.st  = ST_HOLD;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_HOLD: begin
                    r_d.st  = ST_CNT;
                    r_d.cnt = '0;
                end
                ST_CNT: begin
                    if (r_q.cnt == CW'(LAT - 1)) r_d.st = ST_RUN;
                    else                         r_d.cnt = r_q.cnt + 1'b1;
                end
                default: r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_HOLD, cnt: '0, ss: 1'b0, sr: 1'b0, dp: 1'b0};
        else        r_q <= r_d;
    end

    assign en_o = (r_q.st == ST_RUN);

    // R9: any active source stops the dividers on the next edge
    a_r9_hold_stops: assert property (@(posedge clk) disable iff (!rst_n)
        hold_raw |=> (r_q.st == ST_HOLD && !en_o));

    // R3: the countdown advances one step per quiet edge
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CNT && !hold_raw && r_q.cnt != CW'(LAT - 1))
        |=> (r_q.st == ST_CNT && r_q.cnt == CW'($past(r_q.cnt) + 1'b1)));

    // R3: a full countdown releases the dividers
    a_r3_release_full: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CNT && !hold_raw && r_q.cnt == CW'(LAT - 1)) |=> en_o);

    // R7: active copies of staged bits move only on the strobe
    a_r7_stage_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(r_q.ss) && $stable(r_q.sr) && $stable(r_q.dp)));
endmodule

// File: rtl/divsync_chan.sv
module divsync_chan #(
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          excl,
    input  logic [DW-1:0] div_m1,
    input  logic [DW-1:0] phase,
    input  logic          start,
    output logic          out
);
    localparam int RW = DW + 1;

    typedef struct packed {
        logic [DW-1:0] c;
        logic          inv;
    } chan_t;

    chan_t         r_d, r_q;
    logic [RW-1:0] ratio;
    logic [RW-1:0] half;
    logic [RW-1:0] pre_w;
    logic [DW-1:0] pre;
    logic          run;

    always_comb begin
        ratio = {1'b0, div_m1} + 1'b1;
        half  = ratio - (ratio >> 1);
        pre_w = {1'b0, phase} % ratio;
        pre   = pre_w[DW-1:0];
        run   = en | excl;
        r_d   = r_q;
        if (!run) begin
            r_d.c   = pre;
            r_d.inv = 1'b0;
        end else if (div_m1 == '0) begin
            r_d.c   = '0;
            r_d.inv = ~r_q.inv;
        end else begin
            r_d.c   = (r_q.c >= div_m1) ? '0 : r_q.c + 1'b1;
            r_d.inv = ({1'b0, r_d.c} >= half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{c: '0, inv: 1'b0};
        else        r_q <= r_d;
    end

    assign out = start ^ r_q.inv;

    // R2: a stopped, non-excluded channel sits at its start level with the preload
    a_r2_hold_static: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !excl) |=> (out == $past(start) && r_q.c == $past(pre)));

    // R4: the counter never leaves the range of the ratio
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (r_q.c <= $past(div_m1)));
endmodule

// File: rtl/divsync_top.sv
module divsync_top #(
    parameter int NCH = 4,
    parameter int DW  = 5,
    parameter int LAT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              pwrdn,
    input  logic              cal_busy,
    input  logic              soft_sync_stage,
    input  logic              soft_rst_stage,
    input  logic              dist_pd_stage,
    input  logic              upd_strobe,
    input  logic [NCH-1:0]    ch_excl,
    input  logic [NCH*DW-1:0] ch_div_m1,
    input  logic [NCH*DW-1:0] ch_phase,
    input  logic [NCH-1:0]    ch_start,
    output logic [NCH-1:0]    ch_out,
    output logic              hold_o
);
    logic pin_s;
    logic en;

    divsync_pinsync u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (sync_n),
        .pin_s (pin_s)
    );

    divsync_ctrl #(.LAT(LAT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .pwrdn    (pwrdn),
        .cal_busy (cal_busy),
        .ss_stage (soft_sync_stage),
        .sr_stage (soft_rst_stage),
        .dp_stage (dist_pd_stage),
        .upd      (upd_strobe),
        .en_o     (en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        divsync_chan #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .excl   (ch_excl[i]),
            .div_m1 (ch_div_m1[i*DW +: DW]),
            .phase  (ch_phase[i*DW +: DW]),
            .start  (ch_start[i]),
            .out    (ch_out[i])
        );
    end

    assign hold_o = ~en;
endmodule

// File: tb/tb_divsync_top.sv
`timescale 1ns/1ps
module tb_divsync_top;
    localparam int NCH = 4;
    localparam int DW  = 5;
    localparam int LAT = 11;
    localparam int NV  = 5;

    localparam int VR [NV][NCH] = '{'{2,3,4,1}, '{5,6,7,8}, '{32,31,16,9}, '{2,2,2,2}, '{10,1,12,3}};
    localparam int VP [NV][NCH] = '{'{0,0,0,0}, '{1,2,3,9}, '{31,0,15,20}, '{0,1,0,1}, '{25,7,5,2}};
    localparam logic [NCH-1:0] VS [NV] = '{4'b0000, 4'b1010, 4'b1111, 4'b0101, 4'b0011};

    logic clk = 1'b0;
    logic rst_n, sync_n, pwrdn, cal_busy;
    logic soft_sync_stage, soft_rst_stage, dist_pd_stage, upd_strobe;
    logic [NCH-1:0]    ch_excl, ch_start, ch_out;
    logic [NCH*DW-1:0] ch_div_m1, ch_phase;
    logic              hold_o;

    int cur_r [NCH];
    int cur_p [NCH];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    divsync_top #(.NCH(NCH), .DW(DW), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pwrdn(pwrdn), .cal_busy(cal_busy),
        .soft_sync_stage(soft_sync_stage), .soft_rst_stage(soft_rst_stage),
        .dist_pd_stage(dist_pd_stage), .upd_strobe(upd_strobe), .ch_excl(ch_excl),
        .ch_div_m1(ch_div_m1), .ch_phase(ch_phase), .ch_start(ch_start),
        .ch_out(ch_out), .hold_o(hold_o)
    );

    task automatic chk(input logic act, input logic exp, input string req, input int ch);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d t=%0t actual=%b expected=%b", req, ch, $time, act, exp);
        end
    endtask

    task automatic apply_cfg(input int v);
        for (int c = 0; c < NCH; c++) begin
            cur_r[c] = VR[v][c];
            cur_p[c] = VP[v][c];
            ch_div_m1[c*DW +: DW] = DW'(VR[v][c] - 1);
            ch_phase[c*DW +: DW]  = DW'(VP[v][c]);
        end
        ch_start = VS[v];
    endtask

    // expected level after the j-th divider step since release (R4, R5)
    function automatic logic exp_lvl(input int r, input int ph, input logic st, input int j);
        int c;
        if (r == 1) return (j % 2 == 0) ? ~st : st;
        c = ((ph % r) + 1 + j) % r;
        return (c >= r - r / 2) ? ~st : st;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // sample after edges 0..first+span, edge 0 being the next posedge (R10: all channels same edge)
    task automatic verify_release(input int first, input string req);
        for (int k = 0; k <= first + 24; k++) begin
            tick();
            upd_strobe = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                if (!ch_excl[c])
                    chk(ch_out[c], (k < first) ? ch_start[c] : exp_lvl(cur_r[c], cur_p[c], ch_start[c], k - first), req, c);
            end
        end
    endtask

    task automatic chk_static(input string req);
        for (int c = 0; c < NCH; c++)
            if (!ch_excl[c]) chk(ch_out[c], ch_start[c], req, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sync_n = 1'b1; pwrdn = 1'b0; cal_busy = 1'b0;
        soft_sync_stage = 1'b0; soft_rst_stage = 1'b0; dist_pd_stage = 1'b0;
        upd_strobe = 1'b0; ch_excl = '0;
        apply_cfg(1);
        repeat (3) tick();
        chk_static("R1 in reset");
        chk(hold_o, 1'b1, "R1 hold in reset", 0);
        rst_n = 1'b1;
        verify_release(LAT + 1, "R1 release after reset");

        // table walk: pin sync under several ratio/phase/start patterns
        for (int v = 0; v < NV; v++) begin
            apply_cfg(v);
            sync_n = 1'b0;
            repeat (4) tick();
            chk_static("R2 pin held low");
            repeat (2) tick();
            sync_n = 1'b1;
            verify_release(LAT + 3, "R3 R4 R5 R10 pin release");
        end

        // R6: excluded channel keeps dividing through a sync
        apply_cfg(3);
        ch_excl = 4'b0001;
        sync_n = 1'b0;
        repeat (4) tick();
        for (int i = 0; i < 6; i++) begin
            logic prev;
            prev = ch_out[0];
            tick();
            chk(ch_out[0], ~prev, "R6 excluded toggles", 0);
            chk_static("R6 others static");
        end
        sync_n = 1'b1;
        verify_release(LAT + 3, "R6 release with exclusion");
        ch_excl = '0;

        // R7: staged soft sync needs the strobe for set and clear
        soft_sync_stage = 1'b1;
        for (int i = 0; i < 5; i++) begin
            logic prev;
            prev = ch_out[1];
            tick();
            chk(ch_out[1], ~prev, "R7 staged set ignored", 1);
        end
        upd_strobe = 1'b1;
        tick();
        upd_strobe = 1'b0;
        repeat (3) tick();
        chk_static("R7 strobe applies set");
        soft_sync_stage = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk_static("R7 staged clear ignored");
        end
        upd_strobe = 1'b1;
        verify_release(LAT + 2, "R7 strobe applies clear");

        // R8: other staged bits and direct sources
        apply_cfg(4);
        soft_rst_stage = 1'b1; upd_strobe = 1'b1;
        tick(); upd_strobe = 1'b0;
        repeat (4) tick();
        chk_static("R8 soft reset hold");
        soft_rst_stage = 1'b0; upd_strobe = 1'b1;
        verify_release(LAT + 2, "R8 soft reset release");

        apply_cfg(2);
        dist_pd_stage = 1'b1; upd_strobe = 1'b1;
        tick(); upd_strobe = 1'b0;
        repeat (4) tick();
        chk_static("R8 dist pd hold");
        dist_pd_stage = 1'b0; upd_strobe = 1'b1;
        verify_release(LAT + 2, "R8 dist pd release");

        apply_cfg(1);
        pwrdn = 1'b1;
        repeat (5) tick();
        chk_static("R8 pwrdn hold");
        pwrdn = 1'b0;
        verify_release(LAT + 1, "R8 pwrdn release");

        apply_cfg(0);
        cal_busy = 1'b1;
        repeat (5) tick();
        chk_static("R8 cal hold");
        cal_busy = 1'b0;
        verify_release(LAT + 1, "R8 cal release");

        // R9: a new request in the countdown restarts it
        apply_cfg(4);
        sync_n = 1'b0;
        repeat (5) tick();
        sync_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk_static("R9 countdown static");
        end
        sync_n = 1'b0;
        tick();
        sync_n = 1'b1;
        verify_release(LAT + 3, "R9 restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule